// File: doc/BRIEF.md
# ADC Regular-Group Scan Sequencer

This block decides which analog input an ADC converts next and when it converts it. It holds a table of up to sixteen rank slots, each naming a channel, and a programmable sequence length. When a start event arrives, it walks the table forward from the first rank. For each rank it issues a one-cycle start pulse with the channel number to the converter core. It then waits for the core's done pulse, flags the end of that conversion, and flags the end of the sequence after the last rank.

A start event comes either from a software strobe or from one of several external trigger lines. The active edge of an external line can be rising, falling or both. Three scan modes are offered:

- Single: one pass of the sequence per start event.
- Continuous: after the first start event, passes repeat until a stop request.
- Discontinuous: each start event converts a short burst of ranks and then waits, resuming at the next rank.

Configuration writes are refused while a conversion is in progress. A mode write that would enable continuous and discontinuous operation together is also refused.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After reset the block is idle with no pulses out. The defaults are software start, a sequence length of one rank, single mode, and every rank slot set to channel 0.
- R2: Configuration address 16+k holds the channel of rank k+1 in data bits [4:0]. Any channel 0..31 may be placed in any rank, and one channel may occupy several ranks.
- R3: Address 3, bits [3:0], holds the sequence length minus one. Ranks are converted in ascending order from rank 1 to the last rank. `convChannel` carries the channel of the rank being converted from the `convStart` pulse until its done pulse.
- R4: In single mode (address 0, bit0=0 and bit1=0), one start event converts every rank of the sequence once and then returns to idle.
- R5: In continuous mode (address 0 bit0=1), passes repeat with no further start events. A `stopReq` pulse lets the running conversion finish, returns the block to idle, and puts the next conversion back at rank 1.
- R6: In discontinuous mode (address 0 bit1=1, bits [4:2] = burst length minus one), each start event converts that many ranks and then waits. The next event resumes at the following rank. A burst also ends at the last rank, and the pointer then wraps to rank 1.
- R7: A write to address 0 with bit0 and bit1 both set is refused as a whole, and the previous mode stays in force.
- R8: Address 1, bits [2:0], selects the start source: 0 is the software strobe, and n from 1 to 4 is external line n-1. Every write to address 1 resets the edge to rising. Address 2, bits [1:0], selects the edge: 0 is rising, 1 is falling, and 2 or 3 is both. Start events from a source that is not selected have no effect.
- R9: An external line passes through a two-flop synchronizer. A qualifying edge driven just after one falling clock edge shows as `convStart` at the third falling clock edge after that.
- R10: Start events that arrive while the block is busy are ignored.
- R11: Configuration writes are ignored while `busy` is high. An accepted write while idle returns the rank pointer to rank 1.
- R12: `eocPulse` pulses with each done pulse from the core. `eosPulse` pulses together with the `eocPulse` of the last rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration address |
| cfgWdata | input | 5 | Configuration write data |
| swStart | input | 1 | Software start strobe |
| extTrig | input | 4 | Asynchronous external trigger lines |
| stopReq | input | 1 | Request to stop after the running conversion |
| convDone | input | 1 | Done pulse from the converter core |
| convStart | output | 1 | One-cycle start pulse to the converter core |
| convChannel | output | 5 | Channel to convert |
| eocPulse | output | 1 | End of one rank's conversion |
| eosPulse | output | 1 | End of the sequence |
| busy | output | 1 | A regular conversion is in progress |

## Verification
The assertions take for granted that the converter core answers each `convStart` with exactly one `convDone`, some cycles later, and never pulses `convDone` while the block is idle or before it has seen a start. The bench guarantees this with a core model that raises `convDone` a fixed number of cycles after each start pulse. External lines are moved only well apart from each other, and configuration is written mostly while idle. The only writes made while busy are the deliberate ones that test the lock.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

  // Width of the configuration data bus; every field fits in it.
  localparam int CFG_W = 5;

  // Configuration addresses.
  localparam int ADDR_MODE = 0;
  localparam int ADDR_TRIG = 1;
  localparam int ADDR_EDGE = 2;
  localparam int ADDR_LEN  = 3;
  localparam int RANK_BASE = 16;

  // Edge selection codes; any other value means both edges.
  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT
  } seqState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic advance;   // step rank pointer and burst counter
    logic burstClr;  // new start event: restart burst count
    logic ptrClr;    // stop: pointer back to rank 1
  } seqStrobe_t;

endpackage

// File: rtl/seqr_datapath.sv
module seqr_datapath
  import seqr_pkg::*;
#(
  parameter int NUM_RANKS = 16,
  parameter int CH_W      = 5,
  parameter int NUM_EXT   = 4,
  parameter int ADDR_W    = 5,
  parameter int BURST_W   = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cfgWe,
  input  logic [ADDR_W-1:0]                  cfgAddr,
  input  logic [CFG_W-1:0]                   cfgWdata,
  input  logic                               swStart,
  input  logic [NUM_EXT-1:0]                 extTrig,
  input  logic                               busy,
  input  seqStrobe_t                         strobe,
  output logic                               trigHit,
  output logic                               atLast,
  output logic                               burstEnd,
  output logic                               contMode,
  output logic                               discMode,
  output logic [$clog2(NUM_RANKS)-1:0]       seqLenM1,
  output logic [$clog2(NUM_EXT+1)-1:0]       trigSrc,
  output logic [CH_W-1:0]                    curCh
);

  localparam int PTR_W = $clog2(NUM_RANKS);
  localparam int SRC_W = $clog2(NUM_EXT + 1);

  logic [BURST_W-1:0] discNum;
  logic [1:0]         trigEdge;
  logic [CH_W-1:0]    rankTab [NUM_RANKS];
  logic [PTR_W-1:0]   rankPtr;
  logic [BURST_W-1:0] burstCnt;
  logic [NUM_EXT-1:0] sync1, sync2, prevLvl, lineHit;
  logic               wrOk;

  assign wrOk = cfgWe && !busy;

  // Configuration registers, written only while idle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      contMode <= 1'b0;
      discMode <= 1'b0;
      discNum  <= '0;
      trigSrc  <= '0;
      trigEdge <= EDGE_RISE;
      seqLenM1 <= '0;
      for (int k = 0; k < NUM_RANKS; k++) rankTab[k] <= '0;
    end else if (wrOk) begin
      if (cfgAddr == ADDR_W'(ADDR_MODE) && !(cfgWdata[0] && cfgWdata[1])) begin
        contMode <= cfgWdata[0];
        discMode <= cfgWdata[1];
        discNum  <= cfgWdata[2 +: BURST_W];
      end
      if (cfgAddr == ADDR_W'(ADDR_TRIG)) begin
        trigSrc  <= cfgWdata[SRC_W-1:0];
        trigEdge <= EDGE_RISE;
      end
      if (cfgAddr == ADDR_W'(ADDR_EDGE)) trigEdge <= cfgWdata[1:0];
      if (cfgAddr == ADDR_W'(ADDR_LEN)) begin
        if (cfgWdata[PTR_W-1:0] > PTR_W'(NUM_RANKS - 1))
          seqLenM1 <= PTR_W'(NUM_RANKS - 1);
        else
          seqLenM1 <= cfgWdata[PTR_W-1:0];
      end
      for (int k = 0; k < NUM_RANKS; k++)
        if (cfgAddr == ADDR_W'(RANK_BASE + k)) rankTab[k] <= cfgWdata[CH_W-1:0];
    end
  end

  // Rank pointer and burst counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rankPtr  <= '0;
      burstCnt <= '0;
    end else begin
      if (strobe.ptrClr || wrOk) rankPtr <= '0;
      else if (strobe.advance)   rankPtr <= atLast ? '0 : rankPtr + 1'b1;
      if (strobe.burstClr)       burstCnt <= '0;
      else if (strobe.advance)   burstCnt <= burstCnt + 1'b1;
    end
  end

  assign atLast   = (rankPtr == seqLenM1);
  assign burstEnd = (burstCnt == discNum);
  assign curCh    = rankTab[rankPtr];

  // Two-flop synchronizer and per-line edge detect.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1   <= '0;
      sync2   <= '0;
      prevLvl <= '0;
    end else begin
      sync1   <= extTrig;
      sync2   <= sync1;
      prevLvl <= sync2;
    end
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_line
    always_comb begin
      unique case (trigEdge)
        EDGE_RISE: lineHit[i] = sync2[i] && !prevLvl[i];
        EDGE_FALL: lineHit[i] = !sync2[i] && prevLvl[i];
        default:   lineHit[i] = sync2[i] != prevLvl[i];
      endcase
    end
  end

  always_comb begin
    trigHit = (trigSrc == '0) ? swStart : 1'b0;
    for (int i = 0; i < NUM_EXT; i++)
      if (trigSrc == SRC_W'(i + 1)) trigHit = lineHit[i];
  end

endmodule

// File: rtl/seqr_control.sv
module seqr_control
  import seqr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigHit,
  input  logic       convDone,
  input  logic       stopReq,
  input  logic       atLast,
  input  logic       burstEnd,
  input  logic       contMode,
  input  logic       discMode,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       convStart,
  output logic       eocPulse,
  output logic       eosPulse
);

  seqState_t stateQ, stateD;
  logic      stopPend;

  always_comb begin
    stateD    = stateQ;
    strobe    = '0;
    convStart = 1'b0;
    eocPulse  = 1'b0;
    eosPulse  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (trigHit) begin
          strobe.burstClr = 1'b1;
          stateD          = ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        convStart = 1'b1;
        stateD    = ST_WAIT;
      end
      ST_WAIT: begin
        if (convDone) begin
          eocPulse       = 1'b1;
          eosPulse       = atLast;
          strobe.advance = 1'b1;
          if (stopPend || stopReq) begin
            strobe.ptrClr = 1'b1;
            stateD        = ST_IDLE;
          end else if (discMode) begin
            stateD = (burstEnd || atLast) ? ST_IDLE : ST_LAUNCH;
          end else if (atLast) begin
            stateD = contMode ? ST_LAUNCH : ST_IDLE;
          end else begin
            stateD = ST_LAUNCH;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      stopPend <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE) stopPend <= 1'b0;
      else if (stopReq)      stopPend <= 1'b1;
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import seqr_pkg::*;
#(
  parameter int NUM_RANKS = 16,
  parameter int CH_W      = 5,
  parameter int NUM_EXT   = 4,
  parameter int ADDR_W    = 5,
  parameter int MAX_BURST = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgWdata,
  input  logic               swStart,
  input  logic [NUM_EXT-1:0] extTrig,
  input  logic               stopReq,
  input  logic               convDone,
  output logic               convStart,
  output logic [CH_W-1:0]    convChannel,
  output logic               eocPulse,
  output logic               eosPulse,
  output logic               busy
);

  localparam int PTR_W   = $clog2(NUM_RANKS);
  localparam int SRC_W   = $clog2(NUM_EXT + 1);
  localparam int BURST_W = $clog2(MAX_BURST);

  seqStrobe_t       strobe;
  logic             trigHit, atLast, burstEnd, contMode, discMode;
  logic [PTR_W-1:0] seqLenM1;
  logic [SRC_W-1:0] trigSrc;

  seqr_datapath #(
    .NUM_RANKS(NUM_RANKS), .CH_W(CH_W), .NUM_EXT(NUM_EXT),
    .ADDR_W(ADDR_W), .BURST_W(BURST_W)
  ) u_dp (
    .clk, .rstN, .cfgWe, .cfgAddr, .cfgWdata, .swStart, .extTrig,
    .busy, .strobe, .trigHit, .atLast, .burstEnd, .contMode, .discMode,
    .seqLenM1, .trigSrc, .curCh(convChannel)
  );

  seqr_control u_ctl (
    .clk, .rstN, .trigHit, .convDone, .stopReq, .atLast, .burstEnd,
    .contMode, .discMode, .strobe, .busy, .convStart, .eocPulse, .eosPulse
  );

endmodule

// File: rtl/scan_seq_ctrl_chk.sv
module scan_seq_ctrl_chk #(
  parameter int NUM_RANKS = 16,
  parameter int CH_W      = 5,
  parameter int NUM_EXT   = 4
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         cfgWe,
  input logic                         busy,
  input logic                         convStart,
  input logic [CH_W-1:0]              convChannel,
  input logic                         eocPulse,
  input logic                         eosPulse,
  input logic                         contMode,
  input logic                         discMode,
  input logic [$clog2(NUM_RANKS)-1:0] seqLenM1,
  input logic [$clog2(NUM_EXT+1)-1:0] trigSrc
);

  // R12: end of sequence only together with an end of conversion
  p_eos_with_eoc_r12: assert property (@(posedge clk) disable iff (!rstN)
    eosPulse |-> eocPulse);

  // R3: each launch is a single-cycle pulse
  p_one_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R3: channel held from launch until the done pulse
  p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy && !convStart |-> $stable(convChannel));

  // R7: continuous and discontinuous never active together
  p_mode_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(contMode && discMode));

  // R11: configuration frozen while busy
  p_cfg_lock_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy && cfgWe |=> $stable(seqLenM1) && $stable(trigSrc) && $stable(contMode));

endmodule

bind scan_seq_ctrl scan_seq_ctrl_chk #(
  .NUM_RANKS(NUM_RANKS), .CH_W(CH_W), .NUM_EXT(NUM_EXT)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .busy(busy), .convStart(convStart),
  .convChannel(convChannel), .eocPulse(eocPulse), .eosPulse(eosPulse),
  .contMode(contMode), .discMode(discMode), .seqLenM1(seqLenM1), .trigSrc(trigSrc)
);

// File: tb/scan_seq_ctrl_test.sv
`timescale 1ns/1ps
module scan_seq_ctrl_test;
  localparam int LAT = 4;
  localparam int VEC_N = 4;
  localparam int VEC_LEN  [VEC_N] = '{1, 3, 7, 16};
  localparam int VEC_SEED [VEC_N] = '{5, 2, 11, 0};
  localparam int VEC_STEP [VEC_N] = '{5, 0, 7, 3};
  localparam int VEC_EOC  [VEC_N] = '{1, 3, 7, 16};

  logic       clk = 0, rstN = 0, cfgWe = 0, swStart = 0, stopReq = 0, convDone = 0;
  logic [4:0] cfgAddr = 0, cfgWdata = 0;
  logic [3:0] extTrig = 0;
  logic       convStart, eocPulse, eosPulse, busy;
  logic [4:0] convChannel;

  int nChk = 0, nFail = 0, cyc = 0, nStart = 0, nEoc = 0, nEos = 0;
  int startCyc = 0, setCyc = 0, adcCnt = 0;
  int startLog [64];
  bit done = 0;

  scan_seq_ctrl uut (
    .clk, .rstN, .cfgWe, .cfgAddr, .cfgWdata, .swStart, .extTrig, .stopReq,
    .convDone, .convStart, .convChannel, .eocPulse, .eosPulse, .busy
  );

  always #10 clk = ~clk;

  // Converter core model: done pulse a fixed time after each start.
  always @(posedge clk) begin
    if (!rstN) begin
      adcCnt   <= 0;
      convDone <= 0;
    end else begin
      convDone <= (adcCnt == 1);
      if (convStart) adcCnt <= LAT;
      else if (adcCnt != 0) adcCnt <= adcCnt - 1;
    end
  end

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (convStart) begin
        if (nStart < 64) startLog[nStart] = convChannel;
        nStart++;
        startCyc = cyc;
      end
      if (eocPulse) nEoc++;
      if (eosPulse) nEos++;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrCfg(input int addr, input int data);
    @(negedge clk); #1;
    cfgWe = 1; cfgAddr = 5'(addr); cfgWdata = 5'(data);
    @(negedge clk); #1;
    cfgWe = 0;
  endtask

  task automatic pulseSw();
    @(negedge clk); #1 swStart = 1;
    @(negedge clk); #1 swStart = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk); #1 stopReq = 1;
    @(negedge clk); #1 stopReq = 0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    #1;
  endtask

  task automatic clearLog();
    nStart = 0; nEoc = 0; nEos = 0;
  endtask

  task automatic setExt(input int line, input logic v);
    @(negedge clk); #1;
    extTrig[line] = v;
    setCyc = cyc;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin : main
    int contCh [3];
    repeat (5) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;
    // R1: reset state
    checkEq("R1 busy", busy, 0);
    checkEq("R1 convStart", convStart, 0);
    checkEq("R1 eoc", eocPulse, 0);
    checkEq("R1 eos", eosPulse, 0);
    clearLog(); pulseSw(); waitIdle();
    checkEq("R1 default one rank", nStart, 1);
    checkEq("R1 default channel", startLog[0], 0);
    checkEq("R1 default eos", nEos, 1);

    // R2 R3 R4 R12: table of single-mode scans
    for (int v = 0; v < VEC_N; v++) begin
      for (int k = 0; k < VEC_LEN[v]; k++)
        wrCfg(16 + k, (VEC_SEED[v] + VEC_STEP[v] * k) % 19);
      wrCfg(3, VEC_LEN[v] - 1);
      wrCfg(0, 0);
      clearLog(); pulseSw(); waitIdle();
      checkEq("R4 starts per pass", nStart, VEC_LEN[v]);
      checkEq("R12 eoc count", nEoc, VEC_EOC[v]);
      checkEq("R12 eos count", nEos, 1);
      for (int k = 0; k < VEC_LEN[v]; k++)
        checkEq("R2 R3 rank channel order", startLog[k],
                (VEC_SEED[v] + VEC_STEP[v] * k) % 19);
    end

    // R5: continuous mode, then stop
    contCh = '{4, 9, 2};
    for (int k = 0; k < 3; k++) wrCfg(16 + k, contCh[k]);
    wrCfg(3, 2);
    wrCfg(0, 1);
    clearLog(); pulseSw();
    for (int i = 0; i < 300 && nStart < 7; i++) @(negedge clk);
    pulseStop(); waitIdle();
    checkEq("R5 repeats without trigger", int'(nStart >= 7), 1);
    checkEq("R5 idle after stop", busy, 0);
    for (int k = 0; k < nStart && k < 64; k++)
      checkEq("R5 continuous order", startLog[k], contCh[k % 3]);
    checkEq("R12 eoc per start", nEoc, nStart);
    checkEq("R12 eos per pass", nEos, nStart / 3);
    wrCfg(0, 0);
    clearLog(); pulseSw(); waitIdle();
    checkEq("R5 restart at rank 1", startLog[0], 4);

    // R10: start events during a conversion are ignored
    wrCfg(3, 0);
    clearLog(); pulseSw(); pulseSw(); waitIdle();
    checkEq("R10 busy trigger ignored", nStart, 1);

    // R11: writes while busy are ignored
    clearLog(); pulseSw(); wrCfg(3, 2); wrCfg(16, 17); waitIdle();
    clearLog(); pulseSw(); waitIdle();
    checkEq("R11 length locked", nStart, 1);
    checkEq("R11 rank locked", startLog[0], 4);

    // R6: discontinuous, burst 2 over 5 ranks
    for (int k = 0; k < 5; k++) wrCfg(16 + k, k + 1);
    wrCfg(3, 4);
    wrCfg(0, 2 | (1 << 2));
    clearLog(); pulseSw(); waitIdle();
    checkEq("R6 first burst size", nStart, 2);
    checkEq("R6 no eos mid sequence", nEos, 0);
    pulseSw(); waitIdle(); pulseSw(); waitIdle();
    checkEq("R6 short burst at end", nStart, 5);
    checkEq("R6 eos at last rank", nEos, 1);
    pulseSw(); waitIdle();
    checkEq("R6 wrap count", nStart, 7);
    for (int k = 0; k < 7; k++)
      checkEq("R6 burst order", startLog[k], (k % 5) + 1);

    // R11: accepted write returns pointer to rank 1
    wrCfg(0, 2);
    clearLog(); pulseSw(); waitIdle();
    wrCfg(20, 9);
    pulseSw(); waitIdle();
    checkEq("R11 pointer cleared by write", startLog[1], 1);

    // R7: both mode bits set is refused; burst-of-one stays in force
    wrCfg(0, 3);
    clearLog(); pulseSw(); waitCycles(40);
    checkEq("R7 refused combination", busy, 0);
    checkEq("R7 single burst kept", nStart, 1);
    if (busy) begin pulseStop(); waitIdle(); end

    // R8 R9: external trigger lines and edges
    wrCfg(0, 0); wrCfg(3, 0);
    wrCfg(1, 2);
    clearLog();
    setExt(0, 1); waitCycles(15);
    checkEq("R8 unselected line ignored", nStart, 0);
    pulseSw(); waitCycles(15);
    checkEq("R8 software ignored with line", nStart, 0);
    setExt(1, 1); waitCycles(15);
    checkEq("R8 rising start", nStart, 1);
    checkEq("R9 sync latency", startCyc - setCyc, 3);
    setExt(1, 0); waitCycles(15);
    checkEq("R8 falling ignored in rising", nStart, 1);
    wrCfg(2, 1);
    setExt(1, 1); waitCycles(15);
    checkEq("R8 rising ignored in falling", nStart, 1);
    setExt(1, 0); waitCycles(15);
    checkEq("R8 falling start", nStart, 2);
    wrCfg(2, 2);
    setExt(1, 1); waitCycles(15);
    setExt(1, 0); waitCycles(15);
    checkEq("R8 both edges", nStart, 4);
    wrCfg(2, 1);
    wrCfg(1, 2);
    setExt(1, 1); waitCycles(15);
    checkEq("R8 source write restores rising", nStart, 5);
    wrCfg(1, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule